// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Target

This block is a read-only serial EEPROM target that a host operates one line level at a time. Each update strobe presents new SCL and SDA levels. The block compares them with the levels it recorded on the previous update. From that comparison it finds the bus conditions (START, STOP) and the rising clock edges that carry bits.

A transfer begins with a START. It carries a command byte and an acknowledge slot, then an address byte and a second acknowledge slot. After the address byte, the byte held at that address is loaded into an output shift register. If a later transfer's command has its least significant bit set, the block drives that register onto SDA, most significant bit first, while the host clocks the address phase.

The 256-byte contents are fixed when the design is built, and the parameters compute them. The host reads back the SDA level the block last drove. Updates arrive as a plain valid strobe with no ready signal. The block accepts one update in every cycle that `upd_valid` is high, so it never applies back-pressure. The result of an update is visible on `sda_out` in the next cycle.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset, `sda_out` is 1, the bit counter is 0 and no acknowledge is pending.
- R2: A START is an update in which SCL is high both before and after, and SDA goes from 1 to 0. A START sets the bit counter to 1 and clears the command byte. A STOP is the same with SDA rising; it changes no counter, so bits clocked after a STOP keep counting.
- R3: While the bit counter is 0 and no acknowledge is pending, every update other than a START leaves the counter and acknowledge state unchanged. `sda_out` then only echoes the host's SDA.
- R4: A bit is taken on a rising SCL (0 before, 1 after) only if the new SDA equals the recorded SDA. If SDA changes in the same update as the rising SCL, the bit is dropped and the counter does not advance.
- R5: Counter values 1 to 8 shift the received bits into the command byte, MSB first. When the counter reaches 9, an acknowledge is scheduled. The next rising SCL drives `sda_out` to 0 and clears the pending acknowledge.
- R6: The next eight accepted bits shift into the address, MSB first. On the eighth of them, the byte at that address is loaded into the output register, an acknowledge is scheduled and the counter returns to 0.
- R7: While the command LSB is 1, each accepted address-phase bit drives `sda_out` with the output register's MSB, and the register shifts left by one. On the last such bit, the old LSB goes out in the same update that loads the new byte.
- R8: The byte stored at address a is (a*37 + 11) mod 256.
- R9: `sda_out` holds the SDA level last recorded: the host's SDA, or the level the block drove on a rising edge. Nothing changes in cycles without a strobe.
- R10: Any update that is not an accepted rising edge stores the host's SDA, which appears on `sda_out` one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update strobe; one level pair taken per cycle |
| scl_in | input | 1 | Host SCL level for this update |
| sda_in | input | 1 | Host SDA level for this update |
| sda_out | output | 1 | Last recorded SDA level, as seen by the host |

## Verification
Two functions can fall in the same update. One is the output drive of the read path, which sends the old LSB of the output register. The other is the load of a new byte at the end of the address phase. Both happen on the eighth address bit of a read-command transfer. The bench provokes this case by addressing byte 5 in a write-command transfer and then reading with all-ones address bits. It requires that the eighth bit returns byte 5's LSB, that the acknowledge follows, and that a further read returns the byte at address 255.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic same;
  } bus_ev_t;

  function automatic int unsigned img_value(input int unsigned a,
                                            input int unsigned mul,
                                            input int unsigned add,
                                            input int unsigned width);
    return (a * mul + add) % (1 << width);
  endfunction

endpackage

// File: rtl/i2cee_edge.sv
module i2cee_edge
  import i2cee_pkg::*;
(
  input  logic    upd,
  input  logic    scl_q,
  input  logic    sda_q,
  input  logic    scl_in,
  input  logic    sda_in,
  output bus_ev_t ev
);
  logic cond;

  // SDA moving while SCL is held high is a bus condition
  assign cond     = upd & scl_q & scl_in & (sda_q != sda_in);
  assign ev.start = cond & ~sda_in;
  assign ev.stop  = cond & sda_in;
  assign ev.rise  = upd & ~scl_q & scl_in;
  assign ev.same  = (sda_q == sda_in);
endmodule

// File: rtl/i2cee_rom.sv
module i2cee_rom #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IMG_MUL = 37,
  parameter int IMG_ADD = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import i2cee_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] image [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_img
    localparam logic [DATA_W-1:0] VAL =
      DATA_W'(img_value(i, IMG_MUL, IMG_ADD, DATA_W));
    assign image[i] = VAL;
  end

  assign data = image[addr];
endmodule

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TICK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              scl_in,
  input  logic              sda_in,
  input  bus_ev_t           ev,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              scl_q,
  output logic              sda_q,
  output logic [TICK_W-1:0] tick,
  output logic              ack_pend
);
  localparam logic [TICK_W-1:0] ACK_T = TICK_W'(CMD_W + 1);
  localparam logic [TICK_W-1:0] END_T = TICK_W'(CMD_W + ADDR_W + 1);

  logic [CMD_W-1:0]  cmd, cmd_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic [DATA_W-1:0] data, data_n;
  logic [TICK_W-1:0] tick_n, tick_inc;
  logic              ack_n, sda_n;

  assign tick_inc = tick + 1'b1;
  assign rom_addr = {addr[ADDR_W-2:0], sda_in};

  always_comb begin
    cmd_n  = cmd;
    addr_n = addr;
    data_n = data;
    tick_n = tick;
    ack_n  = ack_pend;
    sda_n  = sda_in;
    if (ev.start) begin
      tick_n = TICK_W'(1);
      cmd_n  = '0;
    end else if (ev.stop) begin
      tick_n = tick;
    end else if (tick == '0 && !ack_pend) begin
      tick_n = tick;
    end else if (ev.rise) begin
      if (ack_pend) begin
        sda_n = 1'b0;
        ack_n = 1'b0;
      end else if (ev.same) begin
        if (tick < ACK_T) begin
          cmd_n  = {cmd[CMD_W-2:0], sda_in};
          tick_n = tick_inc;
          if (tick_inc == ACK_T) ack_n = 1'b1;
        end else if (tick < END_T) begin
          if (cmd[0]) sda_n = data[DATA_W-1];
          addr_n = rom_addr;
          data_n = data << 1;
          tick_n = tick_inc;
          if (tick_inc == END_T) begin
            data_n = rom_data;
            ack_n  = 1'b1;
            tick_n = '0;
          end
        end else begin
          sda_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= '0;
      addr     <= '0;
      data     <= '0;
      tick     <= '0;
      ack_pend <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else if (upd) begin
      cmd      <= cmd_n;
      addr     <= addr_n;
      data     <= data_n;
      tick     <= tick_n;
      ack_pend <= ack_n;
      scl_q    <= scl_in;
      sda_q    <= sda_n;
    end
  end
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int CMD_W   = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IMG_MUL = 37,
  parameter int IMG_ADD = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_valid,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out
);
  import i2cee_pkg::*;
  localparam int TICK_W = $clog2(CMD_W + ADDR_W + 2);

  bus_ev_t           ev;
  logic              scl_q, sda_q, ack_pend;
  logic [TICK_W-1:0] tick;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              ev_start, ev_rise;

  i2cee_edge u_edge (
    .upd(upd_valid), .scl_q(scl_q), .sda_q(sda_q),
    .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
  );

  i2cee_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .IMG_MUL(IMG_MUL), .IMG_ADD(IMG_ADD)) u_rom (
    .addr(rom_addr), .data(rom_data)
  );

  i2cee_ctrl #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
               .TICK_W(TICK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .upd(upd_valid), .scl_in(scl_in),
    .sda_in(sda_in), .ev(ev), .rom_data(rom_data), .rom_addr(rom_addr),
    .scl_q(scl_q), .sda_q(sda_q), .tick(tick), .ack_pend(ack_pend)
  );

  assign ev_start = ev.start;
  assign ev_rise  = ev.rise;
  assign sda_out  = sda_q;
endmodule

// File: rtl/i2cee_chk.sv
module i2cee_chk #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int TICK_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              sda_in,
  input logic              sda_out,
  input logic [TICK_W-1:0] tick,
  input logic              ack_pend,
  input logic              ev_start,
  input logic              ev_rise
);
  localparam logic [TICK_W-1:0] END_T = TICK_W'(CMD_W + ADDR_W + 1);

  p_start_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> tick == TICK_W'(1));

  p_idle_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && tick == '0 && !ack_pend && !ev_start) |=> (tick == '0 && !ack_pend));

  p_ack_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && ack_pend && ev_rise && !ev_start) |=> (!sda_out && !ack_pend));

  p_tick_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick < END_T);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(sda_out) && $stable(tick) && $stable(ack_pend)));

  p_echo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !ev_rise) |=> sda_out == $past(sda_in));
endmodule

bind eeprom_i2c_target i2cee_chk #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .sda_in(sda_in),
  .sda_out(sda_out), .tick(tick), .ack_pend(ack_pend),
  .ev_start(ev_start), .ev_rise(ev_rise)
);

// File: tb/sim_eeprom_i2c_target.sv
module sim_eeprom_i2c_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic sda_out;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  eeprom_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
    .scl_in(scl_in), .sda_in(sda_in), .sda_out(sda_out)
  );

  function automatic logic [7:0] img(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic d, output logic r);
    @(negedge clk);
    upd_valid = 1'b1; scl_in = c; sda_in = d;
    @(negedge clk);
    upd_valid = 1'b0;
    r = sda_out;
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    logic x;
    step(1'b0, b, x);
    step(1'b1, b, r);
    step(1'b0, b, x);
  endtask

  task automatic do_start();
    logic x;
    step(1'b1, 1'b1, x);
    step(1'b1, 1'b0, x);
    step(1'b0, 1'b0, x);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], r[i]);
  endtask

  task automatic t_reset();
    check("R1 reset sda_out", {7'd0, sda_out}, 8'd1);
  endtask

  task automatic t_idle();
    logic [7:0] r;
    logic a;
    send_byte(8'hFF, r);
    bit_xfer(1'b1, a);
    check("R3 idle bits echo", r, 8'hFF);
    check("R3 no ack without START", {7'd0, a}, 8'd1);
  endtask

  task automatic t_set_addr();
    logic [7:0] r;
    logic a;
    do_start();
    send_byte(8'hA0, r);
    check("R5 command phase echo", r, 8'hA0);
    bit_xfer(1'b1, a);
    check("R5 command ack low", {7'd0, a}, 8'd0);
    send_byte(8'h05, r);
    check("R6 address phase echo on write command", r, 8'h05);
    step(1'b0, 1'b1, a);
    step(1'b1, 1'b1, a);
    check("R6 address ack low", {7'd0, a}, 8'd0);
    repeat (5) @(negedge clk);
    check("R9 driven low held without strobe", {7'd0, sda_out}, 8'd0);
    step(1'b0, 1'b1, a);
    check("R10 host level stored after falling SCL", {7'd0, a}, 8'd1);
  endtask

  task automatic t_read();
    logic [7:0] r;
    logic a;
    do_start();
    send_byte(8'hA1, r);
    bit_xfer(1'b1, a);
    check("R5 read command ack", {7'd0, a}, 8'd0);
    send_byte(8'hFF, r);
    check("R7 R8 read byte at 5 MSB first", r, img(5));
    bit_xfer(1'b1, a);
    check("R6 ack after load", {7'd0, a}, 8'd0);
    do_start();
    send_byte(8'hA1, r);
    bit_xfer(1'b1, a);
    send_byte(8'hFF, r);
    check("R8 R7 byte at 255", r, img(255));
    bit_xfer(1'b1, a);
    check("R6 second load ack", {7'd0, a}, 8'd0);
  endtask

  task automatic t_discard();
    logic [7:0] r;
    logic a, x;
    do_start();
    step(1'b0, 1'b0, x);
    step(1'b1, 1'b1, x);
    step(1'b0, 1'b1, x);
    send_byte(8'hFF, r);
    check("R4 dropped bit not counted", r, 8'hFF);
    bit_xfer(1'b1, a);
    check("R4 ack after eight accepted bits", {7'd0, a}, 8'd0);
  endtask

  task automatic t_stop();
    logic a, x;
    logic [3:0] r;
    do_start();
    for (int i = 0; i < 3; i++) bit_xfer(1'b1, x);
    step(1'b0, 1'b0, x);
    step(1'b1, 1'b0, x);
    step(1'b1, 1'b1, x);
    check("R2 STOP echoes high", {7'd0, x}, 8'd1);
    for (int i = 3; i >= 0; i--) bit_xfer(1'b1, r[i]);
    check("R2 counting continues after STOP", {4'd0, r}, 8'h0F);
    bit_xfer(1'b1, a);
    check("R2 ack after STOP-spanning command", {7'd0, a}, 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_set_addr();
    t_read();
    t_discard();
    t_stop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule